// File: doc/BRIEF.md
# Two-Band Preemptive Thread Scheduler

This block sits in front of a small coprocessor core and decides which software thread the core runs next. Every request channel has a 3-bit priority level. Levels 4 to 7 form a high band and levels 1 to 3 a low band. Level 0 switches a channel off. A thread running at a low-band level is suspended as soon as a high-band request is pending. A thread running at a high-band level always runs to its end. Only one preemption can be in effect at a time, so a single shadow bank holds the suspended context.

On a preemption the block copies the core's live context into the shadow bank, holds a busy flag for a fixed save time and then starts the preempting thread. When the high-band thread ends, any other pending high-band request starts first. Otherwise the block holds busy for a fixed restore time, presents the saved context with a load strobe and resumes the suspended channel. Requests come from peripheral pulses or from a software trigger input. Each channel raises its own sticky completion interrupt toward the host when its thread ends.

Top module: `thread_sched`

## Requirements
- R1: After a synchronous reset no thread runs (`run_valid_o`=0), `busy_o`=0, `ctx_load_o`=0, `run_start_o`=0 and every `cpl_irq_o` bit is 0.
- R2: Among pending channels the highest level wins, and the lowest channel number wins a tie. A channel whose level is 0 never runs while its level stays 0.
- R3: A request pulse sampled at clock edge k makes the channel pending. If the core is idle, the channel runs from edge k+1 with `run_start_o` high for exactly one cycle.
- R4: When a low-band thread (level 1 to 3) runs and a high-band request (level 4 to 7) is pending, the next edge stores `core_ctx_i` in the shadow bank. `busy_o` is then high and `run_valid_o` low for SAVE_CYC cycles. After that the preempting channel runs with `run_start_o` high.
- R5: A running high-band thread keeps the core until `core_done_i`, whatever requests arrive.
- R6: A low-band request never preempts a low-band thread, even one with a lower level.
- R7: When a high-band thread ends and no high-band request is pending while a context is suspended, the block restores that context. `busy_o` and `ctx_load_o` are high for REST_CYC cycles with `ctx_o` equal to the saved context. The suspended channel then resumes with `run_start_o` low.
- R8: If a high-band request is pending when a high-band thread ends while a context is suspended, that request starts first and the shadow bank keeps the suspended context.
- R9: `core_done_i` during a run sets `cpl_irq_o` bit n (n = running channel) if `cpl_en_i[n]` is 1. The bit stays set until `cpl_ack_i[n]` is high at an edge. A set in the same edge wins over the acknowledge.
- R10: A `sw_trig_i` bit high at an edge makes that channel pending in the same way as a `req_i` pulse.
- R11: If `core_done_i` and a pending preemption meet on one edge, the thread completes. No save happens, and the preempting channel starts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | Peripheral request pulses, one per channel |
| sw_trig_i | input | NCH | Software trigger bits, one per channel |
| level_i | input | NCH*LVL_W | Priority level per channel, channel n at bits n*LVL_W upward |
| core_ctx_i | input | CTX_W | Live register context of the core |
| core_done_i | input | 1 | Running thread has finished |
| cpl_en_i | input | NCH | Completion interrupt enable per channel |
| cpl_ack_i | input | NCH | Completion interrupt clear per channel |
| run_valid_o | output | 1 | Core is running a thread |
| run_ch_o | output | $clog2(NCH) | Channel of the running thread |
| run_start_o | output | 1 | One-cycle pulse: a fresh thread starts |
| busy_o | output | 1 | Context save or restore in progress |
| ctx_load_o | output | 1 | Restore phase: core loads `ctx_o` |
| ctx_o | output | CTX_W | Saved context from the shadow bank |
| cpl_irq_o | output | NCH | Sticky completion interrupts |

## Verification
The bench aims at four cases. The first is a high-band request arriving while a high-band thread runs; a design that checks only the level and not the band would nest a second time and lose the shadow bank. The second is a further high-band request pending when a high thread ends; a wrong design resumes the low thread too early or overwrites the saved context. The third is a completion on the same edge as a preemption, which a wrong design turns into a spurious save of a finished thread. The fourth is equal-level ties and level-0 channels, where a faulty arbiter starts a disabled channel or favours the higher index. The restored context is driven differently from the live one after the save edge, so a design that samples the context late returns the wrong value.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SAVE = 2'd2,
    ST_REST = 2'd3
  } sched_st_e;
endpackage

// File: rtl/sched_arb.sv
module sched_arb #(
  parameter int NCH   = 8,
  parameter int LVL_W = 3,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         pend_i,
  input  logic [NCH*LVL_W-1:0]   lvl_i,
  output logic                   win_vld_o,
  output logic [CH_W-1:0]        win_ch_o,
  output logic [LVL_W-1:0]       win_lvl_o
);
  // Scan downward with >= so the lowest index wins among equal levels.
  always_comb begin
    logic [LVL_W-1:0] lv;
    win_vld_o = 1'b0;
    win_ch_o  = '0;
    win_lvl_o = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      lv = lvl_i[i*LVL_W +: LVL_W];
      if (pend_i[i] && (lv != '0) && (lv >= win_lvl_o)) begin
        win_vld_o = 1'b1;
        win_ch_o  = CH_W'(i);
        win_lvl_o = lv;
      end
    end
  end

  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (rst)
    win_vld_o |-> (pend_i[win_ch_o] && (lvl_i[win_ch_o*LVL_W +: LVL_W] != '0))); // R2
endmodule

// File: rtl/sched_ctx_bank.sv
module sched_ctx_bank #(
  parameter int CTX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CTX_W-1:0] din_i,
  output logic [CTX_W-1:0] dout_o
);
  logic [CTX_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst)       bank_q <= '0;
    else if (wr_i) bank_q <= din_i;
  end

  assign dout_o = bank_q;

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(bank_q)); // R8
endmodule

// File: rtl/sched_cpl.sv
module sched_cpl #(
  parameter int NCH = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic [CH_W-1:0] set_ch_i,
  input  logic [NCH-1:0]  en_i,
  input  logic [NCH-1:0]  ack_i,
  output logic [NCH-1:0]  irq_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = set_i && (set_ch_i == CH_W'(g)) && en_i[g];
    always_ff @(posedge clk) begin
      if (rst)      irq_o[g] <= 1'b0;
      else if (hit) irq_o[g] <= 1'b1;
      else if (ack_i[g]) irq_o[g] <= 1'b0;
    end
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (set_i && en_i[set_ch_i]) |=> irq_o[$past(set_ch_i)]); // R9
endmodule

// File: rtl/thread_sched.sv
module thread_sched #(
  parameter int NCH      = 8,
  parameter int LVL_W    = 3,
  parameter int CTX_W    = 32,
  parameter int SAVE_CYC = 2,
  parameter int REST_CYC = 2,
  parameter int HIGH_MIN = 4,
  localparam int CH_W    = $clog2(NCH),
  localparam int CYC_MAX = (SAVE_CYC > REST_CYC) ? SAVE_CYC : REST_CYC,
  localparam int CNT_W   = $clog2(CYC_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       req_i,
  input  logic [NCH-1:0]       sw_trig_i,
  input  logic [NCH*LVL_W-1:0] level_i,
  input  logic [CTX_W-1:0]     core_ctx_i,
  input  logic                 core_done_i,
  input  logic [NCH-1:0]       cpl_en_i,
  input  logic [NCH-1:0]       cpl_ack_i,
  output logic                 run_valid_o,
  output logic [CH_W-1:0]      run_ch_o,
  output logic                 run_start_o,
  output logic                 busy_o,
  output logic                 ctx_load_o,
  output logic [CTX_W-1:0]     ctx_o,
  output logic [NCH-1:0]       cpl_irq_o
);
  import sched_pkg::*;

  sched_st_e        st_q;
  logic [NCH-1:0]   pend_q;
  logic [CH_W-1:0]  cur_ch_q, susp_ch_q, tgt_ch_q;
  logic [LVL_W-1:0] cur_lvl_q, susp_lvl_q, tgt_lvl_q;
  logic             susp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;

  logic             win_vld;
  logic [CH_W-1:0]  win_ch;
  logic [LVL_W-1:0] win_lvl;
  logic             win_high, cur_high;
  logic             idle_go, preempt, fin;
  logic [NCH-1:0]   clr;

  sched_arb #(.NCH(NCH), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .pend_i(pend_q), .lvl_i(level_i),
    .win_vld_o(win_vld), .win_ch_o(win_ch), .win_lvl_o(win_lvl)
  );

  assign win_high = win_vld && (win_lvl >= LVL_W'(HIGH_MIN));
  assign cur_high = (cur_lvl_q >= LVL_W'(HIGH_MIN));
  // While a context is suspended only high-band work may take the core.
  assign idle_go  = (st_q == ST_IDLE) && win_vld && (!susp_q || win_high);
  assign fin      = (st_q == ST_RUN) && core_done_i;
  assign preempt  = (st_q == ST_RUN) && !core_done_i && !cur_high && win_high;

  always_comb begin
    clr = '0;
    if (idle_go || preempt) clr[win_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      pend_q     <= '0;
      cur_ch_q   <= '0;
      cur_lvl_q  <= '0;
      susp_q     <= 1'b0;
      susp_ch_q  <= '0;
      susp_lvl_q <= '0;
      tgt_ch_q   <= '0;
      tgt_lvl_q  <= '0;
      cnt_q      <= '0;
      start_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      pend_q  <= (pend_q & ~clr) | req_i | sw_trig_i;
      unique case (st_q)
        ST_IDLE: begin
          if (idle_go) begin
            st_q      <= ST_RUN;
            cur_ch_q  <= win_ch;
            cur_lvl_q <= win_lvl;
            start_q   <= 1'b1;
          end else if (susp_q) begin
            st_q  <= ST_REST;
            cnt_q <= CNT_W'(REST_CYC - 1);
          end
        end
        ST_RUN: begin
          if (fin) begin
            st_q <= ST_IDLE;
          end else if (preempt) begin
            st_q       <= ST_SAVE;
            cnt_q      <= CNT_W'(SAVE_CYC - 1);
            susp_q     <= 1'b1;
            susp_ch_q  <= cur_ch_q;
            susp_lvl_q <= cur_lvl_q;
            tgt_ch_q   <= win_ch;
            tgt_lvl_q  <= win_lvl;
          end
        end
        ST_SAVE: begin
          if (cnt_q == '0) begin
            st_q      <= ST_RUN;
            cur_ch_q  <= tgt_ch_q;
            cur_lvl_q <= tgt_lvl_q;
            start_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_REST: begin
          if (cnt_q == '0) begin
            st_q      <= ST_RUN;
            cur_ch_q  <= susp_ch_q;
            cur_lvl_q <= susp_lvl_q;
            susp_q    <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sched_ctx_bank #(.CTX_W(CTX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_i(preempt), .din_i(core_ctx_i), .dout_o(ctx_o)
  );

  sched_cpl #(.NCH(NCH)) u_cpl (
    .clk(clk), .rst(rst), .set_i(fin), .set_ch_i(cur_ch_q),
    .en_i(cpl_en_i), .ack_i(cpl_ack_i), .irq_o(cpl_irq_o)
  );

  assign run_valid_o = (st_q == ST_RUN);
  assign run_ch_o    = cur_ch_q;
  assign run_start_o = start_q;
  assign busy_o      = (st_q == ST_SAVE) || (st_q == ST_REST);
  assign ctx_load_o  = (st_q == ST_REST);

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !run_valid_o); // R4
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_valid_o && cur_high && !core_done_i) |=> (run_valid_o && (run_ch_o == $past(run_ch_o)))); // R5
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_valid_o && !cur_high && !core_done_i && !win_high) |=> (run_valid_o && (run_ch_o == $past(run_ch_o)))); // R6
  AST_ONE_NEST: assert property (@(posedge clk) disable iff (rst)
    (susp_q && run_valid_o) |-> cur_high); // R8
  AST_DONE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (run_valid_o && core_done_i) |=> (!busy_o && !run_valid_o)); // R11
  AST_RESUME_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctx_load_o && (cnt_q == '0)) |=> (run_valid_o && !run_start_o)); // R7
endmodule

// File: tb/thread_sched_tb_top.sv
module thread_sched_tb_top;
  localparam int NCH = 8;
  localparam int SC  = 2;
  localparam int RC  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  req_i = '0, sw_trig_i = '0, cpl_en_i = 8'b1101_1111, cpl_ack_i = '0;
  // levels ch7..ch0 = 4,7,3,0,1,5,5,2
  logic [23:0] level_i = {3'd4, 3'd7, 3'd3, 3'd0, 3'd1, 3'd5, 3'd5, 3'd2};
  logic [31:0] core_ctx_i = '0;
  logic        core_done_i = 1'b0;
  logic        run_valid_o, run_start_o, busy_o, ctx_load_o;
  logic [2:0]  run_ch_o;
  logic [31:0] ctx_o;
  logic [7:0]  cpl_irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  thread_sched #(.NCH(NCH), .SAVE_CYC(SC), .REST_CYC(RC)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .sw_trig_i(sw_trig_i), .level_i(level_i),
    .core_ctx_i(core_ctx_i), .core_done_i(core_done_i), .cpl_en_i(cpl_en_i),
    .cpl_ack_i(cpl_ack_i), .run_valid_o(run_valid_o), .run_ch_o(run_ch_o),
    .run_start_o(run_start_o), .busy_o(busy_o), .ctx_load_o(ctx_load_o),
    .ctx_o(ctx_o), .cpl_irq_o(cpl_irq_o)
  );

  // Behavioural reference: 0 idle, 1 running, 2 saving, 3 restoring
  int m_st, m_cnt, m_cur, m_curlvl, m_susp_ch, m_susp_lvl, m_tgt;
  bit m_susp, m_start;
  bit [7:0] m_pend, m_irq;
  logic [31:0] m_shadow;

  function automatic int lvl(int c);
    return int'(level_i[c*3 +: 3]);
  endfunction

  function automatic int pick(bit [7:0] p);
    for (int l = 7; l >= 1; l--)
      for (int c = 0; c < NCH; c++)
        if (p[c] && lvl(c) == l) return c;
    return -1;
  endfunction

  always @(posedge clk) begin : model
    int w;
    int sc;
    bit [7:0] clr;
    bit setirq;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_cur = 0; m_curlvl = 0; m_susp = 0; m_susp_ch = 0;
      m_susp_lvl = 0; m_tgt = 0; m_start = 0; m_pend = '0; m_irq = '0; m_shadow = '0;
    end else begin
      w = pick(m_pend); clr = '0; m_start = 0; setirq = 0; sc = 0;
      case (m_st)
        0: if (w >= 0 && (!m_susp || lvl(w) >= 4)) begin
             m_st = 1; m_cur = w; m_curlvl = lvl(w); m_start = 1; clr[w] = 1;
           end else if (m_susp) begin
             m_st = 3; m_cnt = RC - 1;
           end
        1: if (core_done_i) begin
             setirq = 1; sc = m_cur; m_st = 0;
           end else if (m_curlvl < 4 && w >= 0 && lvl(w) >= 4) begin
             m_shadow = core_ctx_i; m_susp = 1; m_susp_ch = m_cur; m_susp_lvl = m_curlvl;
             m_tgt = w; clr[w] = 1; m_st = 2; m_cnt = SC - 1;
           end
        2: if (m_cnt == 0) begin
             m_st = 1; m_cur = m_tgt; m_curlvl = lvl(m_tgt); m_start = 1;
           end else m_cnt--;
        default: if (m_cnt == 0) begin
             m_st = 1; m_cur = m_susp_ch; m_curlvl = m_susp_lvl; m_susp = 0;
           end else m_cnt--;
      endcase
      m_irq = m_irq & ~cpl_ack_i;
      if (setirq && cpl_en_i[sc]) m_irq[sc] = 1'b1;
      m_pend = (m_pend & ~clr) | req_i | sw_trig_i;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      check("R3 run_valid", 64'(run_valid_o), 64'(m_st == 1));
      if (m_st == 1) check("R2 run_ch", 64'(run_ch_o), 64'(m_cur));
      check("R3 run_start", 64'(run_start_o), 64'(m_start));
      check("R4 busy", 64'(busy_o), 64'(m_st == 2 || m_st == 3));
      check("R7 ctx_load", 64'(ctx_load_o), 64'(m_st == 3));
      if (m_st == 3) check("R7 ctx", 64'(ctx_o), 64'(m_shadow));
      check("R9 irq", 64'(cpl_irq_o), 64'(m_irq));
    end
  endtask

  task automatic pulse_req(logic [7:0] m);
    req_i = m; tick(); req_i = '0;
  endtask

  task automatic finish_thread();
    core_done_i = 1'b1; tick(); core_done_i = 1'b0;
  endtask

  task automatic wait_run(int ch, string tag);
    for (int i = 0; i < 40; i++) begin
      if (run_valid_o && run_ch_o == 3'(ch)) break;
      tick();
    end
    check(tag, 64'({run_valid_o, run_ch_o}), 64'({1'b1, 3'(ch)}));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1 run_valid", 64'(run_valid_o), 0);
    check("R1 busy", 64'(busy_o), 0);
    check("R1 irq", 64'(cpl_irq_o), 0);
    check("R1 ctx_load/start", 64'({ctx_load_o, run_start_o}), 0);
    rst = 1'b0;
    tick();

    // R2 / R3: ch0 (2), ch4 (0), ch5 (3) together
    pulse_req(8'b0011_0001);
    tick();
    check("R3 first start", 64'({run_valid_o, run_start_o, run_ch_o}), 64'({2'b11, 3'd5}));
    tick();
    check("R3 start pulse single", 64'(run_start_o), 0);
    finish_thread();
    wait_run(0, "R2 next level");
    finish_thread();
    repeat (5) tick();
    check("R2 level0 never runs", 64'(run_valid_o), 0);

    // R6 / R4 / R5 / R8 / R7
    core_ctx_i = 32'hA5A5_0001;
    pulse_req(8'b0000_1000);
    wait_run(3, "R6 low start");
    pulse_req(8'b0010_0000);
    repeat (4) tick();
    check("R6 no low preempt", 64'({run_valid_o, run_ch_o}), 64'({1'b1, 3'd3}));
    pulse_req(8'b0000_0010);
    tick();
    core_ctx_i = 32'h0BAD_0BAD;
    check("R4 save busy", 64'({busy_o, run_valid_o}), 64'(2'b10));
    tick();
    check("R4 save held", 64'(busy_o), 1);
    tick();
    check("R4 preemptor runs", 64'({run_valid_o, run_start_o, run_ch_o}), 64'({2'b11, 3'd1}));
    pulse_req(8'b0100_0000);
    repeat (4) tick();
    check("R5 high not preempted", 64'({run_valid_o, run_ch_o}), 64'({1'b1, 3'd1}));
    finish_thread();
    tick();
    check("R8 high before resume", 64'({run_valid_o, run_start_o, run_ch_o}), 64'({2'b11, 3'd6}));
    finish_thread();
    tick();
    check("R7 restore ctx", 64'({ctx_load_o, busy_o, ctx_o}), 64'({2'b11, 32'hA5A5_0001}));
    tick();
    tick();
    check("R7 resume quiet", 64'({run_valid_o, run_start_o, run_ch_o}), 64'({2'b10, 3'd3}));
    finish_thread();
    wait_run(5, "R6 pending low runs");
    finish_thread();
    tick();
    check("R9 irq set/enable", 64'(cpl_irq_o), 64'(8'b0100_1011));
    cpl_ack_i = 8'hFF; tick(); cpl_ack_i = '0;
    check("R9 irq ack", 64'(cpl_irq_o), 0);

    // R2 tie between ch1 and ch2 (both 5)
    pulse_req(8'b0000_0110);
    wait_run(1, "R2 tie lowest");
    finish_thread();
    wait_run(2, "R2 tie second");
    finish_thread();

    // R10 software trigger
    sw_trig_i = 8'b1000_0000; tick(); sw_trig_i = '0;
    wait_run(7, "R10 sw trigger");
    finish_thread();

    // R11 done meets preemption
    pulse_req(8'b0000_0001);
    wait_run(0, "R11 low start");
    pulse_req(8'b0000_0010);
    core_done_i = 1'b1; tick(); core_done_i = 1'b0;
    check("R11 no save", 64'({busy_o, run_valid_o}), 0);
    tick();
    check("R11 next starts", 64'({run_valid_o, run_ch_o}), 64'({1'b1, 3'd1}));
    finish_thread();
    repeat (4) tick();
    summary();
  end
endmodule